// File: doc/BRIEF.md
# Interrupt Stack Frame Push Sequencer

This block writes an interrupt or exception frame onto a stack in memory, one word per write, through a request/acknowledge write port. A caller that has already validated the event hands it, in one start cycle, the stack pointer and stack segment base, the stack-size and operand-size choices, the register values to save and three layout flags: stack switch, virtual-8086 origin and error code present. The block then walks a fixed slot order, skips the slots that the flags leave out, and writes each value below the previous one.

The working pointer wraps inside 16 bits or 32 bits, depending on the stack-size flag. The committed stack-pointer output is updated only once the last write has been acknowledged. A sequence that stops early, through the abort input or through a write that is never acknowledged, leaves the committed pointer as it was. The caller can then run the whole frame again from the same inputs.

Top module: `irq_frame_pusher`

## Requirements
- R1: The pointer mask is all ones across PTR_W bits when `stk32_i` is 1, and the low HALF_W bits (0xFFFF) when it is 0. Every address and the final pointer wrap inside this mask.
- R2: Before each write the working pointer drops by 4 when `op32_i` is 1, or by 2 when it is 0. The write address is `ss_base_i` plus the masked working pointer, modulo 2^PTR_W, and `wr_wide_o` equals `op32_i`.
- R3: When `op32_i` and `v86_i` are both 1, the first four writes carry the GS, FS, DS and ES selectors, in that order. When `op32_i` is 0 these four writes are left out, whatever `v86_i` is.
- R4: When `new_stack_i` is 1, the old SS selector and then the old stack pointer are written next, before the flags word. When it is 0 both are left out.
- R5: The flags word, the CS selector and the return pointer are always written, in that order. The error code is written last, and only when `err_present_i` is 1.
- R6: The return pointer written is `next_ip_i` when `sw_int_i` is 1, and `cur_ip_i` otherwise.
- R7: With `op32_i` 0, each written value is the low 16 bits of its source, and bits above 16 are zero. With `op32_i` 1, selectors are zero-extended to PTR_W bits.
- R8: One cycle after the final write is acknowledged, `done_o` is 1 for exactly one cycle. In the same cycle `sp_o` takes `sp_i` with its bits outside the mask kept and its bits inside the mask taken from the final working pointer.
- R9: `abort_i` during a pending write, or a write left unacknowledged for ACK_WAIT cycles, ends the sequence with a one-cycle `err_o` and no further write. `sp_o` changes only together with `done_o`. `abort_i` while idle has no effect.
- R10: A pending write keeps `wr_req_o` high, and `wr_addr_o` and `wr_data_o` steady, until it is acknowledged or the sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start a frame; inputs sampled in this cycle while idle |
| abort_i | input | 1 | Abandon the frame in progress |
| sp_i | input | PTR_W | Stack pointer the frame grows down from |
| ss_base_i | input | PTR_W | Stack segment base address |
| stk32_i | input | 1 | 1: 32-bit pointer wrap, 0: 16-bit wrap |
| op32_i | input | 1 | 1: 4-byte writes, 0: 2-byte writes |
| new_stack_i | input | 1 | Stack switch: save old SS and old pointer |
| v86_i | input | 1 | Event came from virtual-8086 code |
| err_present_i | input | 1 | An error code is written |
| sw_int_i | input | 1 | Software interrupt: save the next-instruction address |
| gs_sel_i | input | SEL_W | GS selector |
| fs_sel_i | input | SEL_W | FS selector |
| ds_sel_i | input | SEL_W | DS selector |
| es_sel_i | input | SEL_W | ES selector |
| old_ss_sel_i | input | SEL_W | Old SS selector |
| old_sp_i | input | PTR_W | Old stack pointer |
| flags_i | input | PTR_W | Flags word |
| cs_sel_i | input | SEL_W | CS selector |
| next_ip_i | input | PTR_W | Next-instruction address |
| cur_ip_i | input | PTR_W | Current-instruction address |
| err_code_i | input | PTR_W | Error code |
| wr_req_o | output | 1 | Write request |
| wr_addr_o | output | PTR_W | Write byte address |
| wr_data_o | output | PTR_W | Write data |
| wr_wide_o | output | 1 | 1: 4-byte write, 0: 2-byte write |
| wr_ack_i | input | 1 | Write acknowledge |
| done_o | output | 1 | Frame complete pulse |
| err_o | output | 1 | Frame abandoned pulse |
| sp_o | output | PTR_W | Committed stack pointer |

## Verification
The bench uses PTR_W 32, HALF_W 16 and SEL_W 16 with ACK_WAIT shortened to 4. This keeps the timeout path only a few cycles long. It sweeps all 64 combinations of the six mode flags over three starting pointers. One pointer sits a few bytes above zero, so both the 16-bit and the 32-bit wrap are reached, and the upper-half preservation of the merged pointer can be seen. The acknowledge delay varies from 0 to 2 cycles, and directed runs cover an abort in mid-frame, an acknowledge that never comes, and an abort while idle.

// File: rtl/ifp_pkg.sv
package ifp_pkg;
   localparam int SLOT_N = 10;
   localparam int IDX_W  = $clog2(SLOT_N + 1);
   // slot order is behaviour: lower index is written first
   localparam int S_GS = 0, S_FS = 1, S_DS = 2, S_ES = 3, S_OSS = 4,
                  S_OSP = 5, S_FLG = 6, S_CS = 7, S_RIP = 8, S_ERR = 9;
   typedef enum logic {ST_IDLE, ST_REQ} ifp_state_e;
endpackage

// File: rtl/ifp_slot_pick.sv
module ifp_slot_pick #(
   parameter int N  = 10,
   parameter int IW = 4
) (
   input  logic [N-1:0]  mask_i,
   input  logic [IW-1:0] from_i,
   output logic [IW-1:0] idx_o,
   output logic          found_o
);
   always_comb begin
      idx_o   = '0;
      found_o = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (mask_i[i] && (i >= int'(from_i))) begin
            idx_o   = IW'(i);
            found_o = 1'b1;
         end
      end
   end
endmodule

// File: rtl/ifp_sp_step.sv
module ifp_sp_step #(
   parameter int PTR_W  = 32,
   parameter int HALF_W = 16
) (
   input  logic [PTR_W-1:0] ptr_i,
   input  logic [PTR_W-1:0] orig_i,
   input  logic [PTR_W-1:0] base_i,
   input  logic             op32_i,
   input  logic             stk32_i,
   output logic [PTR_W-1:0] dec_o,
   output logic [PTR_W-1:0] addr_o,
   output logic [PTR_W-1:0] merged_o
);
   localparam logic [PTR_W-1:0] STEP_W = PTR_W'(PTR_W / 8);
   localparam logic [PTR_W-1:0] STEP_N = PTR_W'(HALF_W / 8);
   localparam logic [PTR_W-1:0] MASK_N = PTR_W'({HALF_W{1'b1}});

   logic [PTR_W-1:0] mask;
   assign mask     = stk32_i ? '1 : MASK_N;
   assign dec_o    = ptr_i - (op32_i ? STEP_W : STEP_N);
   assign addr_o   = base_i + (ptr_i & mask);
   assign merged_o = (orig_i & ~mask) | (ptr_i & mask);
endmodule

// File: rtl/ifp_slot_mux.sv
module ifp_slot_mux #(
   parameter int PTR_W  = 32,
   parameter int HALF_W = 16,
   parameter int N      = 10,
   parameter int IW     = 4
) (
   input  logic [N-1:0][PTR_W-1:0] vals_i,
   input  logic [IW-1:0]           idx_i,
   input  logic                    op32_i,
   output logic [PTR_W-1:0]        data_o
);
   logic [PTR_W-1:0] raw;
   assign raw = (int'(idx_i) < N) ? vals_i[idx_i] : '0;

   generate
      if (PTR_W > HALF_W) begin : g_trim
         assign data_o = op32_i ? raw : {{(PTR_W-HALF_W){1'b0}}, raw[HALF_W-1:0]};
      end else begin : g_full
         assign data_o = raw;
      end
   endgenerate
endmodule

// File: rtl/irq_frame_pusher.sv
module irq_frame_pusher
   import ifp_pkg::*;
#(
   parameter int PTR_W    = 32,
   parameter int HALF_W   = 16,
   parameter int SEL_W    = 16,
   parameter int ACK_WAIT = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             abort_i,
   input  logic [PTR_W-1:0] sp_i,
   input  logic [PTR_W-1:0] ss_base_i,
   input  logic             stk32_i,
   input  logic             op32_i,
   input  logic             new_stack_i,
   input  logic             v86_i,
   input  logic             err_present_i,
   input  logic             sw_int_i,
   input  logic [SEL_W-1:0] gs_sel_i,
   input  logic [SEL_W-1:0] fs_sel_i,
   input  logic [SEL_W-1:0] ds_sel_i,
   input  logic [SEL_W-1:0] es_sel_i,
   input  logic [SEL_W-1:0] old_ss_sel_i,
   input  logic [PTR_W-1:0] old_sp_i,
   input  logic [PTR_W-1:0] flags_i,
   input  logic [SEL_W-1:0] cs_sel_i,
   input  logic [PTR_W-1:0] next_ip_i,
   input  logic [PTR_W-1:0] cur_ip_i,
   input  logic [PTR_W-1:0] err_code_i,
   output logic             wr_req_o,
   output logic [PTR_W-1:0] wr_addr_o,
   output logic [PTR_W-1:0] wr_data_o,
   output logic             wr_wide_o,
   input  logic             wr_ack_i,
   output logic             done_o,
   output logic             err_o,
   output logic [PTR_W-1:0] sp_o
);
   localparam int CW = $clog2(ACK_WAIT + 1);

   if (PTR_W < 2 * HALF_W) begin : g_chk_ptr
      $error("PTR_W must be at least twice HALF_W");
   end
   if (SEL_W > PTR_W || SEL_W < 1) begin : g_chk_sel
      $error("SEL_W must lie in 1..PTR_W");
   end
   if (ACK_WAIT < 1) begin : g_chk_wait
      $error("ACK_WAIT must be at least 1");
   end

   ifp_state_e                 state_q;
   logic [IDX_W-1:0]           slot_q;
   logic [CW-1:0]              wait_q;
   logic [PTR_W-1:0]           wp_q, orig_q, base_q;
   logic                       op32_q, stk32_q;
   logic [SLOT_N-1:0][PTR_W-1:0] vals_q, vals_d;
   logic [SLOT_N-1:0]          mask_d, mask_q;

   // slot enables from the mode flags
   always_comb begin
      mask_d        = '0;
      mask_d[S_GS]  = op32_i & v86_i;
      mask_d[S_FS]  = op32_i & v86_i;
      mask_d[S_DS]  = op32_i & v86_i;
      mask_d[S_ES]  = op32_i & v86_i;
      mask_d[S_OSS] = new_stack_i;
      mask_d[S_OSP] = new_stack_i;
      mask_d[S_FLG] = 1'b1;
      mask_d[S_CS]  = 1'b1;
      mask_d[S_RIP] = 1'b1;
      mask_d[S_ERR] = err_present_i;
   end

   always_comb begin
      vals_d        = '0;
      vals_d[S_GS]  = PTR_W'(gs_sel_i);
      vals_d[S_FS]  = PTR_W'(fs_sel_i);
      vals_d[S_DS]  = PTR_W'(ds_sel_i);
      vals_d[S_ES]  = PTR_W'(es_sel_i);
      vals_d[S_OSS] = PTR_W'(old_ss_sel_i);
      vals_d[S_OSP] = old_sp_i;
      vals_d[S_FLG] = flags_i;
      vals_d[S_CS]  = PTR_W'(cs_sel_i);
      vals_d[S_RIP] = sw_int_i ? next_ip_i : cur_ip_i;
      vals_d[S_ERR] = err_code_i;
   end

   logic             idle;
   logic [IDX_W-1:0] first_idx, next_idx;
   logic             first_ok, next_ok;
   logic [PTR_W-1:0] dec, addr, merged;

   assign idle = (state_q == ST_IDLE);

   ifp_slot_pick #(.N(SLOT_N), .IW(IDX_W)) u_first (
      .mask_i(mask_d), .from_i('0), .idx_o(first_idx), .found_o(first_ok));

   ifp_slot_pick #(.N(SLOT_N), .IW(IDX_W)) u_next (
      .mask_i(mask_q), .from_i(slot_q + IDX_W'(1)), .idx_o(next_idx), .found_o(next_ok));

   ifp_sp_step #(.PTR_W(PTR_W), .HALF_W(HALF_W)) u_step (
      .ptr_i   (idle ? sp_i : wp_q),
      .orig_i  (orig_q),
      .base_i  (base_q),
      .op32_i  (idle ? op32_i : op32_q),
      .stk32_i (idle ? stk32_i : stk32_q),
      .dec_o   (dec),
      .addr_o  (addr),
      .merged_o(merged));

   ifp_slot_mux #(.PTR_W(PTR_W), .HALF_W(HALF_W), .N(SLOT_N), .IW(IDX_W)) u_mux (
      .vals_i(vals_q), .idx_i(slot_q), .op32_i(op32_q), .data_o(wr_data_o));

   assign wr_req_o  = (state_q == ST_REQ);
   assign wr_addr_o = addr;
   assign wr_wide_o = op32_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         slot_q  <= '0;
         wait_q  <= '0;
         wp_q    <= '0;
         orig_q  <= '0;
         base_q  <= '0;
         op32_q  <= 1'b0;
         stk32_q <= 1'b0;
         vals_q  <= '0;
         mask_q  <= '0;
         done_o  <= 1'b0;
         err_o   <= 1'b0;
         sp_o    <= '0;
      end else begin
         done_o <= 1'b0;
         err_o  <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_i && first_ok) begin
                  state_q <= ST_REQ;
                  slot_q  <= first_idx;
                  wait_q  <= '0;
                  wp_q    <= dec;
                  orig_q  <= sp_i;
                  base_q  <= ss_base_i;
                  op32_q  <= op32_i;
                  stk32_q <= stk32_i;
                  vals_q  <= vals_d;
                  mask_q  <= mask_d;
               end
            end
            default: begin
               if (abort_i) begin
                  state_q <= ST_IDLE;
                  err_o   <= 1'b1;
               end else if (wr_ack_i) begin
                  wait_q <= '0;
                  if (next_ok) begin
                     slot_q <= next_idx;
                     wp_q   <= dec;
                  end else begin
                     state_q <= ST_IDLE;
                     sp_o    <= merged;
                     done_o  <= 1'b1;
                  end
               end else if (wait_q == CW'(ACK_WAIT - 1)) begin
                  state_q <= ST_IDLE;
                  err_o   <= 1'b1;
               end else begin
                  wait_q <= wait_q + CW'(1);
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/ifp_checker.sv
module ifp_checker #(
   parameter int PTR_W  = 32,
   parameter int HALF_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             abort_i,
   input logic             wr_req_o,
   input logic [PTR_W-1:0] wr_addr_o,
   input logic [PTR_W-1:0] wr_data_o,
   input logic             wr_wide_o,
   input logic             wr_ack_i,
   input logic             done_o,
   input logic             err_o,
   input logic [PTR_W-1:0] sp_o
);
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_o && !wr_ack_i && !abort_i) |=>
         (!wr_req_o || ($stable(wr_addr_o) && $stable(wr_data_o))));

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_end_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o || err_o) |-> !wr_req_o);

   p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o));

   p_sp_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sp_o) |-> done_o);

   p_narrow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_o && !wr_wide_o) |-> (wr_data_o[PTR_W-1:HALF_W] == '0));
endmodule

bind irq_frame_pusher ifp_checker #(.PTR_W(PTR_W), .HALF_W(HALF_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .abort_i(abort_i), .wr_req_o(wr_req_o),
   .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_wide_o(wr_wide_o),
   .wr_ack_i(wr_ack_i), .done_o(done_o), .err_o(err_o), .sp_o(sp_o));

// File: tb/sim_irq_frame_pusher.sv
module sim_irq_frame_pusher;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic        start_i = 0, abort_i = 0, wr_ack_i = 0;
   logic [31:0] sp_i = 0, ss_base_i = 0;
   logic        stk32_i = 0, op32_i = 0, new_stack_i = 0, v86_i = 0, err_present_i = 0, sw_int_i = 0;
   logic [15:0] gs = 16'h1111, fs = 16'h2222, ds = 16'h3333, es = 16'h4444, oss = 16'h5555, cs = 16'h7777;
   logic [31:0] osp = 32'hA5A5_0102, flg = 32'h0002_3246, nip = 32'h8000_1234, cip = 32'h8000_1230, ecode = 32'hE0C0_0018;
   logic        wr_req_o, wr_wide_o, done_o, err_o;
   logic [31:0] wr_addr_o, wr_data_o, sp_o;

   int vectors = 0, fails = 0;

   always #2 clk = ~clk;

   irq_frame_pusher #(.PTR_W(32), .HALF_W(16), .SEL_W(16), .ACK_WAIT(4)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i), .sp_i(sp_i),
      .ss_base_i(ss_base_i), .stk32_i(stk32_i), .op32_i(op32_i), .new_stack_i(new_stack_i),
      .v86_i(v86_i), .err_present_i(err_present_i), .sw_int_i(sw_int_i),
      .gs_sel_i(gs), .fs_sel_i(fs), .ds_sel_i(ds), .es_sel_i(es), .old_ss_sel_i(oss),
      .old_sp_i(osp), .flags_i(flg), .cs_sel_i(cs), .next_ip_i(nip), .cur_ip_i(cip),
      .err_code_i(ecode), .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
      .wr_wide_o(wr_wide_o), .wr_ack_i(wr_ack_i), .done_o(done_o), .err_o(err_o), .sp_o(sp_o));

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // expected frame, computed from the requirements
   logic [31:0] e_addr[10], e_data[10];
   int          e_n;
   logic [31:0] e_sp;

   task automatic build(input logic [5:0] f, input logic [31:0] sp, input logic [31:0] base);
      logic [31:0] mask, step, wp, m, v[$];
      bit o32, s32;
      s32 = f[0]; o32 = f[1];
      mask = s32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;          // R1
      step = o32 ? 32'd4 : 32'd2;                           // R2
      m    = o32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;           // R7
      v = {};
      if (o32 && f[3]) begin v.push_back({16'h0, gs}); v.push_back({16'h0, fs}); v.push_back({16'h0, ds}); v.push_back({16'h0, es}); end // R3
      if (f[2]) begin v.push_back({16'h0, oss}); v.push_back(osp); end  // R4
      v.push_back(flg); v.push_back({16'h0, cs}); v.push_back(f[5] ? nip : cip); // R5, R6
      if (f[4]) v.push_back(ecode);
      wp = sp;
      e_n = v.size();
      for (int k = 0; k < e_n; k++) begin
         wp = wp - step;
         e_addr[k] = base + (wp & mask);
         e_data[k] = v[k] & m;
      end
      e_sp = (sp & ~mask) | (wp & mask);                    // R8
   endtask

   task automatic apply(input logic [5:0] f, input logic [31:0] sp, input logic [31:0] base);
      @(negedge clk);
      {sw_int_i, err_present_i, v86_i, new_stack_i, op32_i, stk32_i} = f;
      sp_i = sp; ss_base_i = base; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      sp_i = 32'hDEAD_BEEF; ss_base_i = 32'h0BAD_0000;   // later inputs must not matter
   endtask

   task automatic run_frame(input logic [5:0] f, input logic [31:0] sp, input logic [31:0] base, input int dly);
      build(f, sp, base);
      apply(f, sp, base);
      for (int k = 0; k < e_n; k++) begin
         chk(wr_req_o === 1'b1, "R2 request", {31'h0, wr_req_o}, 32'h1);
         chk(wr_addr_o === e_addr[k], "R1/R2 address", wr_addr_o, e_addr[k]);
         chk(wr_data_o === e_data[k], "R3-R7 data order", wr_data_o, e_data[k]);
         chk(wr_wide_o === f[1], "R2 width", {31'h0, wr_wide_o}, {31'h0, f[1]});
         for (int d = 0; d < dly; d++) begin
            @(negedge clk);
            chk(wr_req_o && wr_addr_o === e_addr[k] && wr_data_o === e_data[k], "R10 hold", wr_addr_o, e_addr[k]);
         end
         wr_ack_i = 1'b1;
         @(negedge clk);
         wr_ack_i = 1'b0;
      end
      chk(done_o === 1'b1, "R8 done", {31'h0, done_o}, 32'h1);
      chk(sp_o === e_sp, "R8 merged pointer", sp_o, e_sp);
      @(negedge clk);
      chk(done_o === 1'b0 && wr_req_o === 1'b0, "R8 single pulse", {31'h0, done_o}, 32'h0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      logic [31:0] sps[3];
      logic [31:0] held;
      int n;
      sps[0] = 32'h1234_0040; sps[1] = 32'hABCD_0006; sps[2] = 32'h0000_000C;
      repeat (3) @(negedge clk);
      chk(wr_req_o === 0 && done_o === 0 && err_o === 0 && sp_o === 0, "R8 reset state", sp_o, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // exhaustive flag sweep
      for (int s = 0; s < 3; s++)
         for (int f = 0; f < 64; f++)
            run_frame(6'(f), sps[s], 32'h0010_0000 + 32'(s) * 32'h100, (f + s) % 3);

      // R9: abort in the middle leaves sp_o untouched
      held = sp_o;
      build(6'b010111, 32'h0000_2000, 32'h0);
      apply(6'b010111, 32'h0000_2000, 32'h0);
      wr_ack_i = 1'b1; @(negedge clk); wr_ack_i = 1'b0;
      abort_i = 1'b1; @(negedge clk); abort_i = 1'b0;
      chk(err_o === 1'b1, "R9 abort error", {31'h0, err_o}, 32'h1);
      chk(wr_req_o === 1'b0, "R9 abort stops writes", {31'h0, wr_req_o}, 32'h0);
      chk(sp_o === held, "R9 abort keeps pointer", sp_o, held);
      @(negedge clk);
      chk(err_o === 1'b0 && sp_o === held, "R9 error single pulse", sp_o, held);

      // R9: acknowledge never arrives, error after ACK_WAIT (4) cycles
      apply(6'b000011, 32'h0000_3000, 32'h0);
      n = 0;
      while (!err_o && n < 20) begin @(negedge clk); n++; end
      chk(n == 4, "R9 timeout cycles", 32'(n), 32'd4);
      chk(sp_o === held, "R9 timeout keeps pointer", sp_o, held);

      // R9: abort while idle has no effect
      abort_i = 1'b1; @(negedge clk); @(negedge clk); abort_i = 1'b0;
      chk(err_o === 1'b0 && wr_req_o === 1'b0 && sp_o === held, "R9 idle abort ignored", sp_o, held);

      // restart after the abort gives the full frame
      run_frame(6'b010111, 32'h0000_2000, 32'h0, 1);

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule